// File: doc/BRIEF.md
# Coulomb Accumulator with Selectable Current Resolution

This block tracks the charge drawn from or delivered to a battery by summing signed current-conversion results. Each time the converter flags a finished current conversion, the block trims the sample to the selected resolution, holds the trimmed value on its current output, adds it to a signed charge total and increments a conversion count. A one-cycle end-of-conversion pulse marks each accepted result.

A run enable places the block in operating mode or standby. In standby, strobes are ignored and the charge total, count and current output are frozen. A clear pulse zeroes the charge total and the count in either mode. The charge total and the count both saturate rather than wrap, so a long run cannot flip the sign of the reported charge.

Top module: `coulomb_acc`

## Requirements
- R1: While reset is asserted and after its release, `cur_out`, `charge_out` and `conv_cnt` read zero and `eoc_pulse` is low.
- R2: With `res_sel` = 2'b00 (14-bit), an accepted sample appears unchanged on `cur_out` one clock after the strobe edge.
- R3: With `res_sel` = 2'b01 (13-bit), an accepted sample appears on `cur_out` with bit 0 forced to 0 and all other bits kept.
- R4: With `res_sel` = 2'b10 or 2'b11 (12-bit), an accepted sample appears on `cur_out` with bits 1 and 0 forced to 0 and all other bits kept.
- R5: A sample is accepted when `conv_done` and `run_en` are high and `clr_pulse` is low at a clock edge. After that edge, `charge_out` equals the previous total plus the two's complement trimmed sample, sign-extended.
- R6: `eoc_pulse` is high for exactly the one cycle after each edge that accepts a sample, and is low at all other times.
- R7: With `run_en` low, a strobe has no effect. `charge_out`, `conv_cnt` and `cur_out` hold their values and `eoc_pulse` stays low.
- R8: `clr_pulse` high at an edge sets `charge_out` and `conv_cnt` to zero after that edge, whatever the state of `run_en`. `cur_out` keeps its value.
- R9: If `clr_pulse` and `conv_done` are both high at the same edge, the clear wins. The sample is discarded, the count and charge become zero, and `eoc_pulse` stays low.
- R10: `charge_out` saturates at its largest positive value (2^(ACC_W-1)-1) and at its most negative value (-2^(ACC_W-1)) instead of wrapping.
- R11: `conv_cnt` increases by one for each accepted sample and stays at 2^CNT_W-1 (65535 by default) once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = operating mode, 0 = standby (frozen) |
| clr_pulse | input | 1 | Clears the charge total and the conversion count |
| conv_done | input | 1 | Current conversion finished; `cur_sample` is valid |
| cur_sample | input | SMP_W (14) | Signed current sample, two's complement |
| res_sel | input | 2 | Resolution: 00 = 14-bit, 01 = 13-bit, 10/11 = 12-bit |
| cur_out | output | SMP_W (14) | Last accepted sample after resolution trimming |
| charge_out | output | ACC_W (20) | Signed saturating charge total |
| conv_cnt | output | CNT_W (16) | Saturating count of accepted conversions |
| eoc_pulse | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A bad mask shows up on `cur_out` one cycle after the strobe, and only for odd or non-multiple-of-four samples in the narrower modes. The same error is folded into `charge_out` at that edge and stays there until a clear. A wrong accept decision, such as accepting in standby or letting a sample through a clear, changes `eoc_pulse`, the count and the charge one cycle later. Saturation faults stay hidden until the limits are reached. The charge limit is hit after about 64 full-scale samples, and the count limit only after 65535 accepted samples, so both long runs are driven in full.

// File: rtl/coulomb_pkg.sv
package coulomb_pkg;
  typedef enum logic [1:0] {
    RES_14B  = 2'b00,
    RES_13B  = 2'b01,
    RES_12B  = 2'b10,
    RES_12B2 = 2'b11
  } res_mode_e;
endpackage

// File: rtl/cur_mask.sv
module cur_mask
  import coulomb_pkg::*;
#(
  parameter int SMP_W = 14
) (
  input  logic [SMP_W-1:0] smp_in,
  input  logic [1:0]       res_sel,
  output logic [SMP_W-1:0] smp_out
);
  localparam int LOW_MAX = 2;

  logic [LOW_MAX-1:0] drop_bits;

  always_comb begin
    case (res_mode_e'(res_sel))
      RES_14B:  drop_bits = 2'b00;
      RES_13B:  drop_bits = 2'b01;
      default:  drop_bits = 2'b11;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < SMP_W; gi++) begin : g_bit
      if (gi < LOW_MAX) begin : g_low
        assign smp_out[gi] = smp_in[gi] & ~drop_bits[gi];
      end else begin : g_pass
        assign smp_out[gi] = smp_in[gi];
      end
    end
  endgenerate
endmodule

// File: rtl/chg_accum.sv
module chg_accum #(
  parameter int SMP_W = 14,
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [SMP_W-1:0] addend,
  output logic [ACC_W-1:0] acc_q
);
  localparam int EXT_W = ACC_W + 1;
  localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  logic [EXT_W-1:0] sum_ext;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    sum_ext = {acc_q[ACC_W-1], acc_q}
            + {{(EXT_W-SMP_W){addend[SMP_W-1]}}, addend};
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (en) begin
      if (sum_ext[EXT_W-1] != sum_ext[ACC_W-1]) begin
        acc_d = sum_ext[EXT_W-1] ? NEG_LIM : POS_LIM;
      end else begin
        acc_d = sum_ext[ACC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/conv_counter.sv
module conv_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                        cnt_d = '0;
    else if (en && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/coulomb_acc.sv
module coulomb_acc #(
  parameter int SMP_W = 14,
  parameter int ACC_W = 20,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             clr_pulse,
  input  logic             conv_done,
  input  logic [SMP_W-1:0] cur_sample,
  input  logic [1:0]       res_sel,
  output logic [SMP_W-1:0] cur_out,
  output logic [ACC_W-1:0] charge_out,
  output logic [CNT_W-1:0] conv_cnt,
  output logic             eoc_pulse
);
  logic             accept;
  logic [SMP_W-1:0] masked;
  logic [SMP_W-1:0] cur_d;
  logic             eoc_d;

  // a clear takes priority over a strobe in the same cycle
  assign accept = conv_done & run_en & ~clr_pulse;

  cur_mask #(.SMP_W(SMP_W)) u_mask (
    .smp_in  (cur_sample),
    .res_sel (res_sel),
    .smp_out (masked)
  );

  chg_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_pulse),
    .en     (accept),
    .addend (masked),
    .acc_q  (charge_out)
  );

  conv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_pulse),
    .en    (accept),
    .cnt_q (conv_cnt)
  );

  always_comb begin
    cur_d = accept ? masked : cur_out;
    eoc_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_out   <= '0;
      eoc_pulse <= 1'b0;
    end else begin
      cur_out   <= cur_d;
      eoc_pulse <= eoc_d;
    end
  end
endmodule

// File: rtl/coulomb_acc_chk.sv
module coulomb_acc_chk #(
  parameter int SMP_W = 14,
  parameter int ACC_W = 20,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             clr_pulse,
  input logic             conv_done,
  input logic [SMP_W-1:0] cur_sample,
  input logic [1:0]       res_sel,
  input logic [SMP_W-1:0] cur_out,
  input logic [ACC_W-1:0] charge_out,
  input logic [CNT_W-1:0] conv_cnt,
  input logic             eoc_pulse
);
  localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic take;
  assign take = conv_done && run_en && !clr_pulse;

  assert_mask13_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && res_sel == 2'b01) |=> (cur_out[0] == 1'b0));

  assert_mask12_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && res_sel[1]) |=> (cur_out[1:0] == 2'b00));

  assert_eoc_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> eoc_pulse);

  assert_eoc_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !eoc_pulse);

  assert_standby_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr_pulse) |=> ($stable(charge_out) && $stable(conv_cnt) && $stable(cur_out)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (charge_out == '0 && conv_cnt == '0));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && charge_out == POS_LIM && !cur_sample[SMP_W-1]) |=> (charge_out == POS_LIM));

  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && conv_cnt != CNT_MAX) |=> (conv_cnt == $past(conv_cnt) + 1'b1));

  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && conv_cnt == CNT_MAX) |=> (conv_cnt == CNT_MAX));
endmodule

bind coulomb_acc coulomb_acc_chk #(.SMP_W(SMP_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .clr_pulse  (clr_pulse),
  .conv_done  (conv_done),
  .cur_sample (cur_sample),
  .res_sel    (res_sel),
  .cur_out    (cur_out),
  .charge_out (charge_out),
  .conv_cnt   (conv_cnt),
  .eoc_pulse  (eoc_pulse)
);

// File: tb/test_coulomb_acc.sv
module test_coulomb_acc;
  localparam int SMP_W = 14;
  localparam int ACC_W = 20;
  localparam int CNT_W = 16;
  localparam longint CHG_MAX = (64'sd1 <<< (ACC_W-1)) - 1;
  localparam longint CHG_MIN = -(64'sd1 <<< (ACC_W-1));
  localparam longint CNT_TOP = (64'sd1 <<< CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             run_en, clr_pulse, conv_done;
  logic [SMP_W-1:0] cur_sample;
  logic [1:0]       res_sel;
  logic [SMP_W-1:0] cur_out;
  logic [ACC_W-1:0] charge_out;
  logic [CNT_W-1:0] conv_cnt;
  logic             eoc_pulse;

  always #5 clk = ~clk;

  coulomb_acc #(.SMP_W(SMP_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) i_coulomb_acc (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr_pulse(clr_pulse),
    .conv_done(conv_done), .cur_sample(cur_sample), .res_sel(res_sel),
    .cur_out(cur_out), .charge_out(charge_out), .conv_cnt(conv_cnt),
    .eoc_pulse(eoc_pulse)
  );

  typedef struct packed {
    logic [SMP_W-1:0] cur;
    logic [ACC_W-1:0] chg;
    logic [CNT_W-1:0] cnt;
    logic             eoc;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_bad = 0;

  logic [SMP_W-1:0] m_cur = '0;
  longint           m_chg = 0;
  longint           m_cnt = 0;
  logic             m_eoc = 1'b0;

  function automatic logic [SMP_W-1:0] trim(logic [SMP_W-1:0] s, logic [1:0] r);
    if (r == 2'b00)      return s;
    else if (r == 2'b01) return {s[SMP_W-1:1], 1'b0};
    else                 return {s[SMP_W-1:2], 2'b00};
  endfunction

  task automatic apply(input logic run, input logic clr, input logic done,
                       input logic [SMP_W-1:0] smp, input logic [1:0] res,
                       input string tag);
    exp_t e;
    @(negedge clk);
    run_en = run; clr_pulse = clr; conv_done = done; cur_sample = smp; res_sel = res;
    if (clr) begin
      m_chg = 0; m_cnt = 0; m_eoc = 1'b0;
    end else if (run && done) begin
      m_cur = trim(smp, res);
      m_chg = m_chg + longint'($signed(m_cur));
      if (m_chg > CHG_MAX) m_chg = CHG_MAX;
      if (m_chg < CHG_MIN) m_chg = CHG_MIN;
      if (m_cnt < CNT_TOP) m_cnt = m_cnt + 1;
      m_eoc = 1'b1;
    end else begin
      m_eoc = 1'b0;
    end
    e.cur = m_cur; e.chg = m_chg[ACC_W-1:0]; e.cnt = m_cnt[CNT_W-1:0]; e.eoc = m_eoc;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares registered outputs half a cycle after the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (cur_out !== e.cur || charge_out !== e.chg || conv_cnt !== e.cnt || eoc_pulse !== e.eoc) begin
        n_bad++;
        $display("FAIL %s: cur=%h chg=%h cnt=%0d eoc=%b expected cur=%h chg=%h cnt=%0d eoc=%b",
                 t, cur_out, charge_out, conv_cnt, eoc_pulse, e.cur, e.chg, e.cnt, e.eoc);
      end
    end
  end

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; clr_pulse = 1'b0; conv_done = 1'b0;
    cur_sample = '0; res_sel = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (cur_out !== '0 || charge_out !== '0 || conv_cnt !== '0 || eoc_pulse !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: cur=%h chg=%h cnt=%0d eoc=%b expected all zero",
               cur_out, charge_out, conv_cnt, eoc_pulse);
    end
    rst_n = 1'b1;
    apply(1, 0, 0, 14'h0000, 2'b00, "R1 idle after reset");

    // R2 full resolution, R5 accumulation
    apply(1, 0, 1, 14'h0005, 2'b00, "R2/R5 positive");
    apply(1, 0, 1, 14'h3FFD, 2'b00, "R2/R5 negative");
    apply(1, 0, 1, 14'h0123, 2'b00, "R2/R5 mixed");
    apply(1, 0, 0, 14'h1111, 2'b00, "R6 no strobe");
    // R3 13-bit
    apply(1, 0, 1, 14'h0007, 2'b01, "R3 odd positive");
    apply(1, 0, 1, 14'h3FFF, 2'b01, "R3 minus one");
    // R4 12-bit, both codes
    apply(1, 0, 1, 14'h0007, 2'b10, "R4 code 10");
    apply(1, 0, 1, 14'h3FFF, 2'b11, "R4 code 11");
    apply(1, 0, 1, 14'h1FFE, 2'b11, "R4 code 11 bit1");
    // R7 standby
    apply(0, 0, 1, 14'h0064, 2'b00, "R7 standby strobe");
    apply(0, 0, 1, 14'h2000, 2'b00, "R7 standby strobe 2");
    apply(0, 0, 0, 14'h0000, 2'b00, "R7 standby idle");
    // R8 clear while in standby
    apply(0, 1, 0, 14'h0000, 2'b00, "R8 clear in standby");
    apply(1, 0, 1, 14'h0009, 2'b00, "R8 after clear");
    // R9 clear and strobe together
    apply(1, 1, 1, 14'h0033, 2'b00, "R9 clear beats strobe");
    apply(1, 0, 0, 14'h0000, 2'b00, "R9 after");

    // R10 positive saturation
    for (int i = 0; i < 70; i++) apply(1, 0, 1, 14'h1FFF, 2'b00, "R10 positive limit");
    apply(1, 0, 1, 14'h3FFF, 2'b00, "R10 leave positive limit");
    apply(1, 1, 0, 14'h0000, 2'b00, "R8 clear");
    for (int i = 0; i < 70; i++) apply(1, 0, 1, 14'h2000, 2'b00, "R10 negative limit");
    apply(1, 0, 1, 14'h0001, 2'b00, "R10 leave negative limit");

    // R11 count saturation
    apply(1, 1, 0, 14'h0000, 2'b00, "R8 clear");
    for (int i = 0; i < 65540; i++) apply(1, 0, 1, 14'h0000, 2'b00, "R11 count limit");
    apply(1, 0, 0, 14'h0000, 2'b00, "R11 hold");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule